// File: doc/BRIEF.md
# Prefetch Burst Data Serializer

This block connects a wide core data port to a narrow double-data-rate pin stream. One core transfer carries an eight-beat word, 8 x BEAT_W bits wide, in a single clock. At the pins the same data moves as eight BEAT_W-bit beats, two per clock. On the read side a core word is accepted and sent out as beats, with a strobe whose edges line up with the data. On the write side, beats captured from the pins are assembled into one core word with a per-beat write mask. The pins are modelled at clock granularity. Each clock cycle carries a rise-half beat and a fall-half beat, and the strobe is given as its level in each half. No double-speed clock is used.

Both directions start with a one-cycle preamble in which the strobe is held low. Data begins on the first strobe-high half after that. A burst may start at any of the eight beat positions. Beats follow one another from the start position and wrap within the group of eight. A chop option moves only the first four beats. Each direction pulses a done flag during the cycle that carries its last pin beat.

The core-side interfaces are valid/ready. A read word is taken only when `rd_valid && rd_ready`. A write command is taken only when `wr_cmd_valid && wr_cmd_ready`. The assembled write word is offered on `wr_out_valid` and stays stable until `wr_out_ready`. The pin side cannot be stalled. For that reason a new write command is refused while an assembled word is still waiting, so back-pressure from the core reaches the write command instead of the pins.

Top module: `pfx_burst_serdes`

## Requirements
- R1: After reset, `rd_ready` and `wr_cmd_ready` are 1, and `dq_oe_o`, `dqs_rise_o`, `dqs_fall_o`, `rd_done`, `wr_done` and `wr_out_valid` are 0.
- R2: `rd_ready` is 1 only when no read burst is in progress. A word is accepted on a clock edge where `rd_valid && rd_ready`. While a burst runs, `rd_valid` has no effect.
- R3: In the cycle after a read word is accepted (the preamble), `dq_oe_o` is 1, both strobe halves are 0 and both data outputs are 0.
- R4: In data cycle k after the preamble, `dq_rise_o` carries beat (col+2k) mod 8 and `dq_fall_o` carries beat (col+2k+1) mod 8. Beat j is `rd_word[j*BEAT_W +: BEAT_W]`. In these cycles `dqs_rise_o` = 1 and `dqs_fall_o` = 0, so both strobe edges line up with data.
- R5: A full read burst has 4 data cycles (8 beats). With `rd_chop` = 1 it has 2 data cycles (beats 0 to 3 of the order in R4).
- R6: `rd_done` is 1 in the last read data cycle and in no other cycle. In the following cycle `dq_oe_o` = 0 and `rd_ready` = 1.
- R7: `wr_cmd_ready` is 1 only when no write burst is in progress and no assembled word is waiting.
- R8: After a write command is accepted, any cycle with `dqs_i` = 1 is ignored until a cycle with `dqs_i` = 0 (the preamble) has been seen. Capture begins in the first later cycle with `dqs_i` = 1. Extra low cycles before that are also ignored.
- R9: Write beat i (rise half of capture cycle k is beat 2k, fall half is beat 2k+1) is placed at position (col+i) mod 8, that is `wr_out_word[p*BEAT_W +: BEAT_W]`. Positions that are not written read as 0.
- R10: `wr_out_mask` bit p is 1 exactly when position p was written. A full burst gives all ones. A chop (2 capture cycles) sets only the four positions of beats 0 to 3.
- R11: `wr_done` is 1 in the last capture cycle and in no other cycle. `wr_out_valid` rises on the next cycle.
- R12: While `wr_out_valid` = 1 and `wr_out_ready` = 0, the word and mask hold stable. The word is released on the edge where `wr_out_ready` is 1, and `wr_cmd_ready` returns in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read core word offered |
| rd_ready | output | 1 | Read side idle, word can be taken |
| rd_word | input | 8*BEAT_W | Core word to send out, beat j in slice j |
| rd_col | input | 3 | Starting beat position of the read burst |
| rd_chop | input | 1 | Send only four beats |
| dq_rise_o | output | BEAT_W | Read beat in the rising half |
| dq_fall_o | output | BEAT_W | Read beat in the falling half |
| dqs_rise_o | output | 1 | Read strobe level in the rising half |
| dqs_fall_o | output | 1 | Read strobe level in the falling half |
| dq_oe_o | output | 1 | Pin drive enable (preamble and data) |
| rd_done | output | 1 | Last read data cycle |
| wr_cmd_valid | input | 1 | Write burst command offered |
| wr_cmd_ready | output | 1 | Write command can be taken |
| wr_col | input | 3 | Starting beat position of the write burst |
| wr_chop | input | 1 | Capture only four beats |
| dq_rise_i | input | BEAT_W | Write beat sampled in the rising half |
| dq_fall_i | input | BEAT_W | Write beat sampled in the falling half |
| dqs_i | input | 1 | Write strobe level in the rising half |
| wr_done | output | 1 | Last write capture cycle |
| wr_out_valid | output | 1 | Assembled write word available |
| wr_out_ready | input | 1 | Core takes the assembled word |
| wr_out_word | output | 8*BEAT_W | Assembled write word |
| wr_out_mask | output | 8 | Per-position written flag |

## Verification
The bench sweeps every start position, with and without chop, in both directions. It checks the wrap of the beat order at every start position. A design that rotated the wrong way, or failed to wrap, would place beats in the wrong slices. The write sweep adds spurious strobe-high cycles before the preamble and extra low cycles after it. A design that began capturing early would shift every beat by one pair. Chop bursts are checked for the mask and the zeroed lanes, which catches a design that leaves stale data in lanes it did not write. Held-off output cycles check that the word stays stable and that no new command slips in while the word waits.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int BURST  = 8;
  localparam int PAIRS  = BURST / 2;
  localparam int COL_W  = $clog2(BURST);
  localparam int PAIR_W = $clog2(PAIRS);

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_PRE,
    RS_DATA
  } rd_state_t;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_PRE,
    WS_ARM,
    WS_CAP
  } wr_state_t;

  function automatic logic [PAIR_W-1:0] last_pair(input logic chop);
    return chop ? PAIR_W'(PAIRS/2 - 1) : PAIR_W'(PAIRS - 1);
  endfunction

  function automatic logic [COL_W-1:0] pair_pos(input logic [COL_W-1:0] col,
                                                input logic [PAIR_W-1:0] pair,
                                                input logic odd);
    return col + {pair, odd};
  endfunction
endpackage

// File: rtl/pfx_rd_serializer.sv
module pfx_rd_serializer
  import pfx_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [BEAT_W*BURST-1:0]  in_word,
  input  logic [COL_W-1:0]         in_col,
  input  logic                     in_chop,
  output logic [BEAT_W-1:0]        beat_rise,
  output logic [BEAT_W-1:0]        beat_fall,
  output logic                     strobe_rise,
  output logic                     strobe_fall,
  output logic                     drive_en,
  output logic                     done
);
  localparam int CORE_W = BEAT_W * BURST;

  rd_state_t          state;
  logic [CORE_W-1:0]  word_q;
  logic [COL_W-1:0]   col_q;
  logic               chop_q;
  logic [PAIR_W-1:0]  pair_q;
  logic               take;
  logic               at_last;
  logic [COL_W-1:0]   pos_r;
  logic [COL_W-1:0]   pos_f;

  assign in_ready = (state == RS_IDLE);
  assign take     = in_valid && in_ready;
  assign at_last  = (pair_q == last_pair(chop_q));
  assign pos_r    = pair_pos(col_q, pair_q, 1'b0);
  assign pos_f    = pair_pos(col_q, pair_q, 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RS_IDLE;
      word_q <= '0;
      col_q  <= '0;
      chop_q <= 1'b0;
      pair_q <= '0;
    end else begin
      unique case (state)
        RS_IDLE: begin
          if (take) begin
            word_q <= in_word;
            col_q  <= in_col;
            chop_q <= in_chop;
            pair_q <= '0;
            state  <= RS_PRE;
          end
        end
        RS_PRE:  state <= RS_DATA;
        RS_DATA: begin
          if (at_last) state <= RS_IDLE;
          else         pair_q <= pair_q + PAIR_W'(1);
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  always_comb begin
    beat_rise   = '0;
    beat_fall   = '0;
    strobe_rise = 1'b0;
    strobe_fall = 1'b0;
    drive_en    = 1'b0;
    done        = 1'b0;
    unique case (state)
      RS_PRE: drive_en = 1'b1;
      RS_DATA: begin
        drive_en    = 1'b1;
        strobe_rise = 1'b1;
        beat_rise   = word_q[pos_r*BEAT_W +: BEAT_W];
        beat_fall   = word_q[pos_f*BEAT_W +: BEAT_W];
        done        = at_last;
      end
      default: ;
    endcase
  end

  // R2
  rd_busy_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> !in_ready);
  // R3
  rd_preamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> (!strobe_rise && !strobe_fall));
  // R4
  rd_data_follows_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |=> strobe_rise);
  // R6
  rd_done_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!drive_en && in_ready));
  // R6
  rd_done_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> strobe_rise);
endmodule

// File: rtl/pfx_wr_deserializer.sv
module pfx_wr_deserializer
  import pfx_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [COL_W-1:0]         cmd_col,
  input  logic                     cmd_chop,
  input  logic [BEAT_W-1:0]        beat_rise,
  input  logic [BEAT_W-1:0]        beat_fall,
  input  logic                     strobe,
  output logic                     done,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [BEAT_W*BURST-1:0]  out_word,
  output logic [BURST-1:0]         out_mask
);
  localparam int CORE_W = BEAT_W * BURST;

  wr_state_t          state;
  logic [COL_W-1:0]   col_q;
  logic               chop_q;
  logic [PAIR_W-1:0]  pair_q;
  logic               vld_q;
  logic               take;
  logic               capture;
  logic               at_last;
  logic [COL_W-1:0]   pos_r;
  logic [COL_W-1:0]   pos_f;
  logic [CORE_W-1:0]  word_q;
  logic [BURST-1:0]   mask_q;

  assign cmd_ready = (state == WS_IDLE) && !vld_q;
  assign take      = cmd_valid && cmd_ready;
  assign capture   = ((state == WS_ARM) && strobe) || (state == WS_CAP);
  assign at_last   = (pair_q == last_pair(chop_q));
  assign pos_r     = pair_pos(col_q, pair_q, 1'b0);
  assign pos_f     = pair_pos(col_q, pair_q, 1'b1);
  assign done      = (state == WS_CAP) && at_last;
  assign out_valid = vld_q;
  assign out_word  = word_q;
  assign out_mask  = mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= WS_IDLE;
      col_q  <= '0;
      chop_q <= 1'b0;
      pair_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (vld_q && out_ready) vld_q <= 1'b0;
      unique case (state)
        WS_IDLE: begin
          if (take) begin
            col_q  <= cmd_col;
            chop_q <= cmd_chop;
            pair_q <= '0;
            state  <= WS_PRE;
          end
        end
        WS_PRE: if (!strobe) state <= WS_ARM;
        WS_ARM: begin
          if (strobe) begin
            pair_q <= PAIR_W'(1);
            state  <= WS_CAP;
          end
        end
        WS_CAP: begin
          if (at_last) begin
            state <= WS_IDLE;
            vld_q <= 1'b1;
          end else begin
            pair_q <= pair_q + PAIR_W'(1);
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < BURST; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q[g*BEAT_W +: BEAT_W] <= '0;
        mask_q[g]                  <= 1'b0;
      end else if (take) begin
        word_q[g*BEAT_W +: BEAT_W] <= '0;
        mask_q[g]                  <= 1'b0;
      end else if (capture && (pos_r == COL_W'(g))) begin
        word_q[g*BEAT_W +: BEAT_W] <= beat_rise;
        mask_q[g]                  <= 1'b1;
      end else if (capture && (pos_f == COL_W'(g))) begin
        word_q[g*BEAT_W +: BEAT_W] <= beat_fall;
        mask_q[g]                  <= 1'b1;
      end
    end
  end

  // R7
  wr_pending_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);
  // R11
  wr_done_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> out_valid);
  // R12
  wr_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_mask)));
  // R10
  wr_mask_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_mask) == BURST || $countones(out_mask) == BURST/2));
endmodule

// File: rtl/pfx_burst_serdes.sv
module pfx_burst_serdes
  import pfx_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_valid,
  output logic                    rd_ready,
  input  logic [BEAT_W*8-1:0]     rd_word,
  input  logic [2:0]              rd_col,
  input  logic                    rd_chop,
  output logic [BEAT_W-1:0]       dq_rise_o,
  output logic [BEAT_W-1:0]       dq_fall_o,
  output logic                    dqs_rise_o,
  output logic                    dqs_fall_o,
  output logic                    dq_oe_o,
  output logic                    rd_done,
  input  logic                    wr_cmd_valid,
  output logic                    wr_cmd_ready,
  input  logic [2:0]              wr_col,
  input  logic                    wr_chop,
  input  logic [BEAT_W-1:0]       dq_rise_i,
  input  logic [BEAT_W-1:0]       dq_fall_i,
  input  logic                    dqs_i,
  output logic                    wr_done,
  output logic                    wr_out_valid,
  input  logic                    wr_out_ready,
  output logic [BEAT_W*8-1:0]     wr_out_word,
  output logic [7:0]              wr_out_mask
);
  pfx_rd_serializer #(.BEAT_W(BEAT_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (rd_valid),
    .in_ready    (rd_ready),
    .in_word     (rd_word),
    .in_col      (rd_col),
    .in_chop     (rd_chop),
    .beat_rise   (dq_rise_o),
    .beat_fall   (dq_fall_o),
    .strobe_rise (dqs_rise_o),
    .strobe_fall (dqs_fall_o),
    .drive_en    (dq_oe_o),
    .done        (rd_done)
  );

  pfx_wr_deserializer #(.BEAT_W(BEAT_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (wr_cmd_valid),
    .cmd_ready (wr_cmd_ready),
    .cmd_col   (wr_col),
    .cmd_chop  (wr_chop),
    .beat_rise (dq_rise_i),
    .beat_fall (dq_fall_i),
    .strobe    (dqs_i),
    .done      (wr_done),
    .out_valid (wr_out_valid),
    .out_ready (wr_out_ready),
    .out_word  (wr_out_word),
    .out_mask  (wr_out_mask)
  );
endmodule

// File: tb/pfx_burst_serdes_bench.sv
`timescale 1ns/1ps
module pfx_burst_serdes_bench;
  localparam int W = 8;
  localparam int CW = W * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [CW-1:0] rd_word = '0;
  logic [2:0]    rd_col = '0;
  logic          rd_chop = 1'b0;
  logic [W-1:0]  dq_rise_o, dq_fall_o;
  logic          dqs_rise_o, dqs_fall_o, dq_oe_o, rd_done;
  logic          wr_cmd_valid = 1'b0;
  logic          wr_cmd_ready;
  logic [2:0]    wr_col = '0;
  logic          wr_chop = 1'b0;
  logic [W-1:0]  dq_rise_i = '0, dq_fall_i = '0;
  logic          dqs_i = 1'b0;
  logic          wr_done, wr_out_valid;
  logic          wr_out_ready = 1'b0;
  logic [CW-1:0] wr_out_word;
  logic [7:0]    wr_out_mask;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pfx_burst_serdes #(.BEAT_W(W)) u_pfx_burst_serdes (.*);

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] beat_val(input int col, input int i, input int chop, input int tag);
    return W'((col * 29 + i * 53 + chop * 101 + tag * 7 + 3) & 255);
  endfunction

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_read(input int col, input int chop);
    logic [CW-1:0] w;
    int npairs;
    for (int j = 0; j < 8; j++) w[j*W +: W] = beat_val(col, j, chop, 1);
    npairs = chop ? 2 : 4;
    rd_word = w; rd_col = 3'(col); rd_chop = chop[0]; rd_valid = 1'b1;
    #1 chk("R2 ready idle", CW'(rd_ready), CW'(1));
    step();
    // keep rd_valid high during the burst: must be ignored (R2)
    rd_word = ~w;
    chk("R3 oe", CW'(dq_oe_o), CW'(1));
    chk("R3 strobe low", CW'({dqs_rise_o, dqs_fall_o}), CW'(0));
    chk("R3 dq zero", CW'({dq_rise_o, dq_fall_o}), CW'(0));
    chk("R2 busy", CW'(rd_ready), CW'(0));
    for (int k = 0; k < npairs; k++) begin
      step();
      chk("R4 rise beat", CW'(dq_rise_o), CW'(w[((col + 2*k) % 8)*W +: W]));
      chk("R4 fall beat", CW'(dq_fall_o), CW'(w[((col + 2*k + 1) % 8)*W +: W]));
      chk("R4 strobe", CW'({dqs_rise_o, dqs_fall_o}), CW'(2'b10));
      chk("R5 R6 done", CW'(rd_done), CW'(k == npairs - 1));
      if (k == npairs - 1) rd_valid = 1'b0;
    end
    step();
    chk("R6 oe off", CW'(dq_oe_o), CW'(0));
    chk("R6 ready back", CW'(rd_ready), CW'(1));
    chk("R5 no extra", CW'(rd_done), CW'(0));
  endtask

  task automatic run_write(input int col, input int chop, input int junk, input int extra_low, input int hold);
    logic [CW-1:0] ew;
    logic [7:0] em;
    int npairs;
    npairs = chop ? 2 : 4;
    ew = '0; em = '0;
    for (int i = 0; i < 2*npairs; i++) begin
      ew[((col + i) % 8)*W +: W] = beat_val(col, i, chop, 2);
      em[(col + i) % 8] = 1'b1;
    end
    wr_col = 3'(col); wr_chop = chop[0]; wr_cmd_valid = 1'b1; dqs_i = 1'b0;
    #1 chk("R7 cmd ready", CW'(wr_cmd_ready), CW'(1));
    step();
    wr_cmd_valid = 1'b0;
    chk("R7 busy", CW'(wr_cmd_ready), CW'(0));
    for (int j = 0; j < junk; j++) begin
      dqs_i = 1'b1; dq_rise_i = 8'hEE; dq_fall_i = 8'hDD;
      step();
    end
    dqs_i = 1'b0; dq_rise_i = 8'h11; dq_fall_i = 8'h22;
    step();
    for (int j = 0; j < extra_low; j++) step();
    for (int k = 0; k < npairs; k++) begin
      dqs_i = 1'b1;
      dq_rise_i = beat_val(col, 2*k, chop, 2);
      dq_fall_i = beat_val(col, 2*k + 1, chop, 2);
      #1 chk("R11 done", CW'(wr_done), CW'(k == npairs - 1));
      step();
    end
    dqs_i = 1'b0; dq_rise_i = '0; dq_fall_i = '0;
    wr_out_ready = (hold == 0);
    #1;
    chk("R11 valid", CW'(wr_out_valid), CW'(1));
    chk("R8 R9 word", wr_out_word, ew);
    chk("R10 mask", CW'(wr_out_mask), CW'(em));
    for (int h = 0; h < hold; h++) begin
      wr_cmd_valid = 1'b1;
      step();
      chk("R12 held", CW'(wr_out_valid), CW'(1));
      chk("R12 stable", wr_out_word, ew);
      chk("R12 no cmd", CW'(wr_cmd_ready), CW'(0));
      wr_cmd_valid = 1'b0;
    end
    wr_out_ready = 1'b1;
    step();
    wr_out_ready = 1'b0;
    chk("R12 released", CW'(wr_out_valid), CW'(0));
    chk("R12 R7 ready", CW'(wr_cmd_ready), CW'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_ready", CW'(rd_ready), CW'(1));
    chk("R1 wr_cmd_ready", CW'(wr_cmd_ready), CW'(1));
    chk("R1 outputs", CW'({dq_oe_o, dqs_rise_o, dqs_fall_o, rd_done, wr_done, wr_out_valid}), CW'(0));
    rst_n = 1'b1;
    step();
    chk("R1 after reset", CW'({dq_oe_o, rd_done, wr_done, wr_out_valid}), CW'(0));
    for (int c = 0; c < 8; c++)
      for (int ch = 0; ch < 2; ch++)
        run_read(c, ch);
    for (int c = 0; c < 8; c++)
      for (int ch = 0; ch < 2; ch++)
        for (int jk = 0; jk < 2; jk++)
          for (int xl = 0; xl < 2; xl++)
            run_write(c, ch, jk, xl, (c + ch + xl) % 3);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule